// File: doc/BRIEF.md
# Multi-Cycle 16-bit Register Processor Core

This block is a small non-pipelined processor core. It fetches one 16-bit instruction at a time from an instruction memory port and runs it through four fixed phases: fetch, decode, execute and writeback. Its eight 16-bit general-purpose registers are the operands and destinations for arithmetic, logic and shift operations. It can load registers from a separate data memory and store them back. It also supports an unconditional jump and a linking call. Both memory ports use an 8-bit word address and a combinational read: the address is driven from a register and the data is taken in the same cycle.

An instruction has four fields. Bits [15:12] hold the opcode and bits [11:9] the register that is the destination (or the data source for a store). Bit [8] selects the addressing mode and bits [7:0] are an immediate. ALU operations are two-operand: the result replaces the register named in [11:9]. The program counter is visible at a port for test, and a run flag shows when the core has left reset.

Top module: `mini16_core`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter and all eight registers become zero, `running` is low, and `dmem_we` is low. `running` rises on the first edge with `rst` low.
- R2: Opcode 0 (add) and opcode 1 (subtract) work on the register in [11:9] and the register in [2:0] as two's-complement numbers. When the true result does not fit in 16 bits, it clamps to 0x7FFF (positive overflow) or 0x8000 (negative overflow).
- R3: Opcode 2 adds one to the register in [11:9] and opcode 3 subtracts one from it. Both wrap modulo 2^16.
- R4: Opcodes 4, 5, 6 and 7 write the bitwise OR, XOR, AND and NAND of the register in [11:9] and the register in [2:0] to the register in [11:9].
- R5: Shifts use the amount in bits [3:0]. Opcode 8 is a logical right shift and opcode 9 a logical left shift. Opcode 10 is an arithmetic right shift that fills with the sign bit. Opcode 11 is a left shift that keeps the original bit 15 and shifts only bits [14:0].
- R6: Opcode 12 (load) writes memory data into the register in [11:9]. Opcode 13 (store) writes that register to memory. With bit [8] = 0, the address is the 8-bit immediate.
- R7: With bit [8] = 1, the load or store address is the low 8 bits of the register named by bits [2:0].
- R8: Opcode 14 sets the program counter to the 8-bit immediate. The instructions that follow the jump in memory are not executed.
- R9: Opcode 15 writes the address of the next instruction into register 7 and then sets the program counter to the 8-bit immediate.
- R10: Every instruction takes exactly four clock cycles. The program counter advances by one at the end of the fetch cycle. A store asserts `dmem_we` for exactly the third cycle of its instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Instruction word address (the program counter) |
| imem_rdata | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 8 | Data word address for loads and stores |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 16 | Data word at `dmem_addr` |
| pc_out | output | 8 | Current program counter, for test |
| running | output | 1 | High once the core has left reset |

## Verification
Each register result becomes visible only when a later store writes it out. The bench counts rising edges since reset release and expects the store of instruction n in the cycle after edge 4n+2. The monitor checks every `dmem_we` pulse at the falling edge, both for that phase and against the next address/data pair in the scoreboard queue. The reset values are checked at a falling edge while `rst` is held. The first program-counter step is checked at the falling edge after the first fetch edge. Jump targets and the call link are checked the same way: the stores after them must land, and the instructions that are skipped must not produce any write.

// File: rtl/mini16_pkg.sv
package mini16_pkg;
  localparam int XLEN   = 16;
  localparam int AW     = 8;
  localparam int NREG   = 8;
  localparam int RIW    = $clog2(NREG);
  localparam int SHW    = $clog2(XLEN);
  localparam int LINK_R = NREG - 1;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_INC  = 4'd2,  OP_DEC  = 4'd3,
    OP_OR   = 4'd4,  OP_XOR  = 4'd5,  OP_AND  = 4'd6,  OP_NAND = 4'd7,
    OP_SHR  = 4'd8,  OP_SHL  = 4'd9,  OP_SAR  = 4'd10, OP_SAL  = 4'd11,
    OP_LD   = 4'd12, OP_ST   = 4'd13, OP_JMP  = 4'd14, OP_CALL = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2,
    PH_WB     = 2'd3
  } phase_e;

  typedef struct packed {
    opcode_e        op;
    logic [RIW-1:0] rd;
    logic           ind;
    logic [AW-1:0]  imm;
  } instr_t;

  // Two's-complement add or subtract that clamps instead of wrapping.
  function automatic logic [XLEN-1:0] sat_addsub(input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b,
                                                 input logic            sub);
    logic [XLEN-1:0] bx;
    logic [XLEN-1:0] s;
    bx = sub ? ~b : b;
    s  = a + bx + {{(XLEN-1){1'b0}}, sub};
    if ((a[XLEN-1] == bx[XLEN-1]) && (s[XLEN-1] != a[XLEN-1]))
      return a[XLEN-1] ? {1'b1, {(XLEN-1){1'b0}}} : {1'b0, {(XLEN-1){1'b1}}};
    return s;
  endfunction

  // Left shift that leaves the top bit where it was.
  function automatic logic [XLEN-1:0] shl_keep_sign(input logic [XLEN-1:0] a,
                                                    input logic [SHW-1:0]  n);
    logic [XLEN-1:0] t;
    t = a << n;
    return {a[XLEN-1], t[XLEN-2:0]};
  endfunction

  function automatic logic [XLEN-1:0] sar(input logic [XLEN-1:0] a,
                                          input logic [SHW-1:0]  n);
    return $unsigned($signed(a) >>> n);
  endfunction
endpackage

// File: rtl/mini16_regfile.sv
module mini16_regfile
  import mini16_pkg::*;
#(
  parameter int N_REGS = NREG,
  parameter int WIDTH  = XLEN,
  localparam int IW    = $clog2(N_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    ridx_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [IW-1:0]    ridx_b,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] regs [N_REGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_REGS; i++) begin
      if (rst)
        regs[i] <= '0;
      else if (we && (widx == IW'(i)))
        regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[ridx_a];
  assign rdata_b = regs[ridx_b];

  // R1: a write is never accepted during reset.
  a_r1_regs_clear_after_reset: assert property (@(posedge clk)
    rst |=> (regs[0] == '0) && (regs[N_REGS-1] == '0));
endmodule

// File: rtl/mini16_alu.sv
module mini16_alu
  import mini16_pkg::*;
(
  input  opcode_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [SHW-1:0]  shamt,
  output logic [XLEN-1:0] y
);
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      OP_ADD:  y = sat_addsub(a, b, 1'b0);
      OP_SUB:  y = sat_addsub(a, b, 1'b1);
      OP_INC:  y = a + ONE;
      OP_DEC:  y = a - ONE;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_AND:  y = a & b;
      OP_NAND: y = ~(a & b);
      OP_SHR:  y = a >> shamt;
      OP_SHL:  y = a << shamt;
      OP_SAR:  y = sar(a, shamt);
      OP_SAL:  y = shl_keep_sign(a, shamt);
      default: y = '0;
    endcase
  end

  // R2: clamping keeps the sign that the true result would have.
  always_comb begin
    if (!$isunknown({op, a, b})) begin
      if (op == OP_ADD && a[XLEN-1] == b[XLEN-1])
        a_r2_add_sign_kept: assert (y[XLEN-1] == a[XLEN-1])
          else $error("R2 add result changed sign");
      if (op == OP_SUB && a[XLEN-1] != b[XLEN-1])
        a_r2_sub_sign_kept: assert (y[XLEN-1] == a[XLEN-1])
          else $error("R2 sub result changed sign");
      if (op == OP_SAL)
        a_r5_sal_top_bit: assert (y[XLEN-1] == a[XLEN-1])
          else $error("R5 sign-keeping shift lost bit 15");
    end
  end
endmodule

// File: rtl/mini16_decode.sv
module mini16_decode
  import mini16_pkg::*;
(
  input  instr_t         ir,
  output logic           is_load,
  output logic           is_store,
  output logic           is_jump,
  output logic           is_call,
  output logic           writes_reg,
  output logic [RIW-1:0] rs_idx,
  output logic [RIW-1:0] wr_idx
);
  always_comb begin
    is_load    = (ir.op == OP_LD);
    is_store   = (ir.op == OP_ST);
    is_jump    = (ir.op == OP_JMP);
    is_call    = (ir.op == OP_CALL);
    writes_reg = !(is_store || is_jump);
    rs_idx     = ir.imm[RIW-1:0];
    wr_idx     = is_call ? RIW'(LINK_R) : ir.rd;
  end
endmodule

// File: rtl/mini16_core.sv
module mini16_core
  import mini16_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [AW-1:0]   imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [AW-1:0]   dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic [AW-1:0]   pc_out,
  output logic            running
);
  phase_e          phase;
  logic [AW-1:0]   pc;
  instr_t          ir;
  logic [XLEN-1:0] opa, opb, res;
  logic [AW-1:0]   maddr;

  logic            d_load, d_store, d_jump, d_call, d_wr;
  logic [RIW-1:0]  d_rs, d_wi;
  logic [XLEN-1:0] rf_a, rf_b, alu_y;

  // Named events for the assertions.
  logic fetch_fire, wb_fire, branch_fire, rf_we;
  assign fetch_fire  = (phase == PH_FETCH);
  assign wb_fire     = (phase == PH_WB);
  assign branch_fire = wb_fire && (d_jump || d_call);
  assign rf_we       = wb_fire && d_wr;

  mini16_decode u_dec (
    .ir         (ir),
    .is_load    (d_load),
    .is_store   (d_store),
    .is_jump    (d_jump),
    .is_call    (d_call),
    .writes_reg (d_wr),
    .rs_idx     (d_rs),
    .wr_idx     (d_wi)
  );

  mini16_regfile #(.N_REGS(NREG), .WIDTH(XLEN)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .widx    (d_wi),
    .wdata   (res),
    .ridx_a  (ir.rd),
    .rdata_a (rf_a),
    .ridx_b  (d_rs),
    .rdata_b (rf_b)
  );

  mini16_alu u_alu (
    .op    (ir.op),
    .a     (opa),
    .b     (opb),
    .shamt (ir.imm[SHW-1:0]),
    .y     (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_FETCH;
      pc      <= '0;
      ir      <= '0;
      opa     <= '0;
      opb     <= '0;
      res     <= '0;
      maddr   <= '0;
      running <= 1'b0;
    end else begin
      running <= 1'b1;
      unique case (phase)
        PH_FETCH: begin
          ir    <= instr_t'(imem_rdata);
          pc    <= pc + AW'(1);
          phase <= PH_DECODE;
        end
        PH_DECODE: begin
          opa   <= rf_a;
          opb   <= rf_b;
          maddr <= ir.ind ? rf_b[AW-1:0] : ir.imm;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          if (d_load)      res <= dmem_rdata;
          else if (d_call) res <= {{(XLEN-AW){1'b0}}, pc};
          else             res <= alu_y;
          phase <= PH_WB;
        end
        PH_WB: begin
          if (d_jump || d_call) pc <= ir.imm;
          phase <= PH_FETCH;
        end
        default: phase <= PH_FETCH;
      endcase
    end
  end

  assign imem_addr  = pc;
  assign pc_out     = pc;
  assign dmem_addr  = maddr;
  assign dmem_wdata = opa;
  assign dmem_we    = (phase == PH_EXEC) && d_store;

  // R10: fixed four-phase order.
  a_r10_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
    fetch_fire |=> (phase == PH_DECODE));
  a_r10_wb_to_fetch: assert property (@(posedge clk) disable iff (rst)
    wb_fire |=> fetch_fire);
  a_r10_pc_steps_on_fetch: assert property (@(posedge clk) disable iff (rst)
    fetch_fire |=> (pc == $past(pc) + AW'(1)));
  a_r10_pc_held_otherwise: assert property (@(posedge clk) disable iff (rst)
    (!fetch_fire && !branch_fire) |=> $stable(pc));
  a_r10_store_in_exec: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> (phase == PH_WB) && !dmem_we);
  // R8 / R9: control transfer lands on the immediate.
  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    (wb_fire && d_jump) |=> (pc == $past(ir.imm)));
  a_r9_call_links_r7: assert property (@(posedge clk) disable iff (rst)
    (wb_fire && d_call) |-> (rf_we && d_wi == RIW'(LINK_R) && res[AW-1:0] == pc));
endmodule

// File: tb/test_mini16_core.sv
module test_mini16_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr, dmem_addr, pc_out;
  logic [15:0] imem_rdata, dmem_wdata, dmem_rdata;
  logic        dmem_we, running;

  logic [15:0] imem [256];
  logic [15:0] dmem [256];

  int n_checks = 0;
  int n_fail   = 0;
  int edges    = 0;
  bit done     = 1'b0;

  typedef struct { logic [7:0] addr; logic [15:0] data; string req; } wr_t;
  wr_t exp_q [$];

  always #5 clk = ~clk;

  mini16_core i_mini16_core (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .pc_out(pc_out), .running(running)
  );

  assign imem_rdata = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    if (!rst) edges <= edges + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] r,
                                      input logic m, input logic [7:0] i);
    return {op, r, m, i};
  endfunction

  // Driver side of the scoreboard.
  task automatic push_store(input logic [7:0] a, input logic [15:0] d, input string req);
    wr_t w;
    w.addr = a; w.data = d; w.req = req;
    exp_q.push_back(w);
  endtask

  // Monitor: every store pulse is compared with the head of the queue.
  always @(negedge clk) begin
    if (!rst && dmem_we) begin
      check((edges % 4) == 2, "R10", "store phase", 16'(edges % 4), 16'd2);
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected store addr", {8'h0, dmem_addr}, 16'h0);
      end else begin
        wr_t w;
        w = exp_q.pop_front();
        check(dmem_addr == w.addr, w.req, "store addr", {8'h0, dmem_addr}, {8'h0, w.addr});
        check(dmem_wdata == w.data, w.req, "store data", dmem_wdata, w.data);
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin imem[i] = 16'h0; dmem[i] = 16'h0; end
    dmem[8'h10] = 16'h7000; dmem[8'h11] = 16'h2000;
    dmem[8'h12] = 16'h8000; dmem[8'h13] = 16'h0001; dmem[8'h14] = 16'h1250;

    imem[0]  = enc(4'd12, 3'd1, 1'b0, 8'h10);  // R1 = 7000
    imem[1]  = enc(4'd12, 3'd2, 1'b0, 8'h11);  // R2 = 2000
    imem[2]  = enc(4'd0,  3'd1, 1'b0, 8'h02);  // add saturates
    imem[3]  = enc(4'd13, 3'd1, 1'b0, 8'h40);  push_store(8'h40, 16'h7FFF, "R2");
    imem[4]  = enc(4'd12, 3'd3, 1'b0, 8'h12);  // R3 = 8000
    imem[5]  = enc(4'd1,  3'd3, 1'b0, 8'h02);  // sub saturates low
    imem[6]  = enc(4'd13, 3'd3, 1'b0, 8'h41);  push_store(8'h41, 16'h8000, "R2");
    imem[7]  = enc(4'd12, 3'd4, 1'b0, 8'h13);  // R4 = 1
    imem[8]  = enc(4'd0,  3'd4, 1'b0, 8'h02);  // 2001, no clamp
    imem[9]  = enc(4'd13, 3'd4, 1'b0, 8'h42);  push_store(8'h42, 16'h2001, "R2");
    imem[10] = enc(4'd2,  3'd4, 1'b0, 8'h00);
    imem[11] = enc(4'd3,  3'd2, 1'b0, 8'h00);
    imem[12] = enc(4'd13, 3'd4, 1'b0, 8'h43);  push_store(8'h43, 16'h2002, "R3");
    imem[13] = enc(4'd13, 3'd2, 1'b0, 8'h44);  push_store(8'h44, 16'h1FFF, "R3");
    imem[14] = enc(4'd5,  3'd4, 1'b0, 8'h02);
    imem[15] = enc(4'd13, 3'd4, 1'b0, 8'h45);  push_store(8'h45, 16'h3FFD, "R4");
    imem[16] = enc(4'd6,  3'd4, 1'b0, 8'h02);
    imem[17] = enc(4'd13, 3'd4, 1'b0, 8'h46);  push_store(8'h46, 16'h1FFD, "R4");
    imem[18] = enc(4'd7,  3'd4, 1'b0, 8'h02);
    imem[19] = enc(4'd13, 3'd4, 1'b0, 8'h47);  push_store(8'h47, 16'hE002, "R4");
    imem[20] = enc(4'd4,  3'd4, 1'b0, 8'h01);
    imem[21] = enc(4'd13, 3'd4, 1'b0, 8'h48);  push_store(8'h48, 16'hFFFF, "R4");
    imem[22] = enc(4'd10, 3'd3, 1'b0, 8'h03);
    imem[23] = enc(4'd13, 3'd3, 1'b0, 8'h49);  push_store(8'h49, 16'hF000, "R5");
    imem[24] = enc(4'd8,  3'd3, 1'b0, 8'h04);
    imem[25] = enc(4'd13, 3'd3, 1'b0, 8'h4A);  push_store(8'h4A, 16'h0F00, "R5");
    imem[26] = enc(4'd9,  3'd3, 1'b0, 8'h04);
    imem[27] = enc(4'd13, 3'd3, 1'b0, 8'h4B);  push_store(8'h4B, 16'hF000, "R5");
    imem[28] = enc(4'd11, 3'd1, 1'b0, 8'h01);
    imem[29] = enc(4'd13, 3'd1, 1'b0, 8'h4C);  push_store(8'h4C, 16'h7FFE, "R5");
    imem[30] = enc(4'd12, 3'd6, 1'b0, 8'h14);  // R6 = 1250
    imem[31] = enc(4'd13, 3'd1, 1'b1, 8'h06);  push_store(8'h50, 16'h7FFE, "R7");
    imem[32] = enc(4'd12, 3'd5, 1'b1, 8'h06);
    imem[33] = enc(4'd2,  3'd5, 1'b0, 8'h00);
    imem[34] = enc(4'd13, 3'd5, 1'b0, 8'h4D);  push_store(8'h4D, 16'h7FFF, "R7");
    imem[35] = enc(4'd14, 3'd0, 1'b0, 8'd40);
    for (int i = 36; i < 50; i++) imem[i] = enc(4'd13, 3'd1, 1'b0, 8'h4E);
    imem[40] = enc(4'd15, 3'd0, 1'b0, 8'd50);
    imem[50] = enc(4'd13, 3'd7, 1'b0, 8'h4F);  push_store(8'h4F, 16'h0029, "R9");
    imem[51] = enc(4'd14, 3'd0, 1'b0, 8'd51);

    repeat (3) @(negedge clk);
    check(pc_out == 8'h0, "R1", "pc in reset", {8'h0, pc_out}, 16'h0);
    check(running == 1'b0, "R1", "running in reset", {15'h0, running}, 16'h0);
    check(dmem_we == 1'b0, "R1", "we in reset", {15'h0, dmem_we}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check(pc_out == 8'h1, "R10", "pc after first fetch", {8'h0, pc_out}, 16'h1);
    check(running == 1'b1, "R1", "running after reset", {15'h0, running}, 16'h1);
    @(negedge clk);
    check(pc_out == 8'h1, "R10", "pc held in decode", {8'h0, pc_out}, 16'h1);
    repeat (400) @(negedge clk);
    check(exp_q.size() == 0, "R6", "stores left over", 16'(exp_q.size()), 16'h0);
    check(pc_out == 8'd51 || pc_out == 8'd52, "R8", "pc in final loop", {8'h0, pc_out}, 16'd51);
    check(dmem[8'h4E] == 16'h0, "R8", "skipped store", dmem[8'h4E], 16'h0);
    check(dmem[8'h50] == 16'h7FFE, "R7", "indirect memory", dmem[8'h50], 16'h7FFE);
    check(dmem[8'h40] == 16'h7FFF, "R6", "direct memory", dmem[8'h40], 16'h7FFF);
    done = 1'b1;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R10", "watchdog expired", 16'h0, 16'h1);
      done = 1'b1;
    end
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule